// File: doc/BRIEF.md
# Keyed Software Watchdog

This block is a software-serviced watchdog counter driven by a reference clock. A three-bit rate code selects one of eight power-of-two divide counts. The ratios are not evenly spaced: the lower four codes step by a factor of four from 2^9 to 2^15, and the upper four step from 2^18 to 2^24. Software keeps the system alive by writing a two-byte key to the service port. The first byte must be 0x55 and the second 0xAA. If software fails to do this before the count runs out, the block pulses a timeout request for one clock, which a system reset controller would consume.

The rate code applies only when it is committed. A commit happens at the first clock after reset and at every completed key sequence; a change on the rate input alone leaves the running period unchanged. The parameter SCALE_SHIFT lowers every exponent by a fixed amount, so that a simulation can run scaled-down periods; its default of zero gives the full counts. With a 16.777 MHz reference, code 000 gives about 30 µs and code 111 gives about 1 s.

Top module: `sw_watchdog`

## Requirements
- R1: With enable high, the period between timeouts is 2^(E-SCALE_SHIFT) clocks for the committed code, where E is 9, 11, 13, 15, 18, 20, 22 or 24 for codes 000 to 111 in that order. The same count applies from a completed service to the first timeout.
- R2: Each timeout is a pulse exactly one clock wide. After the pulse the counter reloads and keeps counting, so timeouts repeat every period.
- R3: A service is a write of 0x55 followed by a write of 0xAA. It restarts the count. The first timeout after it is asserted on the Nth clock edge after the edge that captured 0xAA.
- R4: A write of 0xAA that does not directly follow an accepted 0x55 does not restart the count. This includes the first writes after reset.
- R5: Any write other than 0x55 or 0xAA, placed between the two key bytes, cancels the pending key. A repeated 0x55 keeps the key pending, so a following 0xAA still completes the service.
- R6: A change on the rate input has no effect on the running period until a service completes. On that service, the value present at the 0xAA write is committed.
- R7: While enable is low, no timeout is produced and the counter holds its full reload value. When enable returns high, the first timeout is asserted on the Nth edge, counting the first edge that sees enable high as edge 1.
- R8: During reset the timeout output is low. The code present at the first clock after reset is committed, the count starts from that clock, and no key byte is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Watchdog enable |
| rate_sel | input | 3 | Rate code, prescale-range bit in the MSB |
| wr_stb | input | 1 | Service register write strobe |
| wr_data | input | 8 | Service register write data |
| timeout | output | 1 | One-clock timeout reset request |

## Verification
The bench goes after the key-ordering corners: a lone 0xAA, including one right after reset; a junk byte between the keys; and a doubled 0x55. A tracker that restarted on a lone 0xAA or a broken sequence would move the next timeout later. A tracker that dropped the pending key on a second 0x55 would let the count expire too early. It changes the rate code without a service, where a design that applied the code at once would show the wrong period. It also drops enable, where a leaky design would pulse timeout or resume from a partly used count. Each of the eight codes is measured at its exact cycle count, since an off-by-one reload or a mis-ordered ratio table shifts every timestamp.

// File: rtl/swd_pkg.sv
package swd_pkg;
  // Exponent of the divide count for a rate code, less the scale shift.
  function automatic int unsigned swd_exp(input logic [2:0] code, input int unsigned shift);
    int unsigned e;
    case (code)
      3'd0: e = 9;
      3'd1: e = 11;
      3'd2: e = 13;
      3'd3: e = 15;
      3'd4: e = 18;
      3'd5: e = 20;
      3'd6: e = 22;
      default: e = 24;
    endcase
    if (e <= shift) return 1;
    return e - shift;
  endfunction

  // Value loaded into the down-counter: the divide count minus one.
  function automatic logic [31:0] swd_reload(input logic [2:0] code, input int unsigned shift);
    return (32'd1 << swd_exp(code, shift)) - 32'd1;
  endfunction
endpackage

// File: rtl/swd_key_seq.sv
module swd_key_seq #(
  parameter logic [7:0] KEY_FIRST  = 8'h55,
  parameter logic [7:0] KEY_SECOND = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic       svc_done
);
  typedef enum logic {KS_IDLE, KS_ARMED} ks_t;
  ks_t st;

  logic hit_first, hit_second;
  assign hit_first  = wr_stb && (wr_data == KEY_FIRST);
  assign hit_second = wr_stb && (wr_data == KEY_SECOND);
  assign svc_done   = (st == KS_ARMED) && hit_second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= KS_IDLE;
    end else if (wr_stb) begin
      if (hit_first) st <= KS_ARMED;
      else           st <= KS_IDLE;
    end
  end

  // R5
  junk_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !hit_first && !hit_second) |=> (st == KS_IDLE && !svc_done));

  // R4
  lone_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !hit_first) |=> !svc_done);
endmodule

// File: rtl/swd_rate_hold.sv
module swd_rate_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic       svc_done,
  output logic [2:0] active_code,
  output logic       primed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_code <= 3'd0;
      primed      <= 1'b0;
    end else begin
      primed <= 1'b1;
      if (!primed || svc_done) active_code <= rate_sel;
    end
  end

  // R6
  hold_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !svc_done) |=> $stable(active_code));

  // R8
  prime_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);
endmodule

// File: rtl/swd_down_cnt.sv
module swd_down_cnt
  import swd_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SCALE_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       primed,
  input  logic       svc_done,
  input  logic [2:0] rate_sel,
  input  logic [2:0] active_code,
  output logic       timeout
);
  localparam int unsigned SHIFT_U = SCALE_SHIFT;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload_new, reload_cur;
  logic             expire_evt;

  assign reload_new = CNT_W'(swd_reload(rate_sel, SHIFT_U));
  assign reload_cur = CNT_W'(swd_reload(active_code, SHIFT_U));
  assign expire_evt = primed && !svc_done && en && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else if (!primed || svc_done) begin
      cnt     <= reload_new;
      timeout <= 1'b0;
    end else if (!en) begin
      cnt     <= reload_cur;
      timeout <= 1'b0;
    end else if (expire_evt) begin
      cnt     <= reload_cur;
      timeout <= 1'b1;
    end else begin
      cnt     <= cnt - 1'b1;
      timeout <= 1'b0;
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  // R7
  en_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !timeout);

  // R3
  svc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && svc_done) |=> (cnt == CNT_W'(swd_reload($past(rate_sel), SHIFT_U))));

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (cnt <= reload_cur || $past(svc_done)));
endmodule

// File: rtl/sw_watchdog.sv
module sw_watchdog #(
  parameter int         CNT_W       = 24,
  parameter int         SCALE_SHIFT = 0,
  parameter logic [7:0] KEY_FIRST   = 8'h55,
  parameter logic [7:0] KEY_SECOND  = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] rate_sel,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic       timeout
);
  logic       svc_done;
  logic       primed;
  logic [2:0] active_code;

  swd_key_seq #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .svc_done(svc_done)
  );

  swd_rate_hold u_rate (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .svc_done(svc_done),
    .active_code(active_code), .primed(primed)
  );

  swd_down_cnt #(.CNT_W(CNT_W), .SCALE_SHIFT(SCALE_SHIFT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .primed(primed), .svc_done(svc_done),
    .rate_sel(rate_sel), .active_code(active_code), .timeout(timeout)
  );

  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !timeout);
endmodule

// File: tb/sim_sw_watchdog.sv
module sim_sw_watchdog;
  localparam int SHIFT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [2:0] rate_sel = 3'd3;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       timeout;

  int checks = 0, failures = 0;
  int cyc = 0, to_count = 0, width_err = 0;
  int to_hist [64];
  logic prev_to = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  sw_watchdog #(.SCALE_SHIFT(SHIFT)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .rate_sel(rate_sel),
    .wr_stb(wr_stb), .wr_data(wr_data), .timeout(timeout)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && timeout) begin
      to_hist[to_count % 64] <= cyc;
      to_count <= to_count + 1;
      if (prev_to) width_err <= width_err + 1;
    end
    prev_to <= timeout;
  end

  function automatic int period_of(input int code);
    int e;
    e = (code >= 4 ? 18 : 9) + 2 * (code % 4);
    return 1 << (e - SHIFT);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    wr_stb = 1'b1; wr_data = b;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic service(output int mark, output int base);
    put(8'h55); put(8'hAA);
    mark = cyc; base = to_count;
  endtask

  task automatic wait_to(input int target);
    int n = 0;
    while (to_count < target && n < 70000) begin @(negedge clk); n++; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int mark, base, mark2, n, junk;
    logic [7:0] b;
    real us;
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(timeout == 1'b0, "R8 timeout low in reset", timeout, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mark = cyc; base = to_count;
    idle(10);
    put(8'hAA);
    wait_to(base + 1);
    chk(to_hist[base % 64] - mark == 128, "R8 R4 first timeout from reset code", to_hist[base % 64] - mark, 128);

    rate_sel = 3'd0;
    base = to_count;
    wait_to(base + 2);
    chk(to_hist[(base + 1) % 64] - to_hist[base % 64] == 128, "R6 uncommitted code ignored",
        to_hist[(base + 1) % 64] - to_hist[base % 64], 128);

    for (int c = 0; c < 8; c++) begin
      rate_sel = 3'(c);
      service(mark, base);
      wait_to(base + 1);
      chk(to_hist[base % 64] - mark == period_of(c), $sformatf("R1 code %0d from service", c),
          to_hist[base % 64] - mark, period_of(c));
      if (c < 7) begin
        wait_to(base + 2);
        chk(to_hist[(base + 1) % 64] - to_hist[base % 64] == period_of(c),
            $sformatf("R2 code %0d repeat period", c),
            to_hist[(base + 1) % 64] - to_hist[base % 64], period_of(c));
      end
      if (c == 0) begin
        us = real'((to_hist[base % 64] - mark) << SHIFT) / 16.777;
        chk(us > 29.0 && us < 32.0, "R1 code 0 near 30us", int'(us), 30);
      end
      if (c == 7) begin
        us = real'((to_hist[base % 64] - mark) << SHIFT) / 16.777;
        chk(us > 990000.0 && us < 1010000.0, "R1 code 7 near 1s", int'(us), 1000000);
      end
    end

    rate_sel = 3'd3;
    service(mark, base); idle(50);
    service(mark2, base);
    wait_to(base + 1);
    chk(to_hist[base % 64] - mark2 == 128, "R3 restart mid count", to_hist[base % 64] - mark2, 128);

    service(mark, base); idle(40); put(8'hAA);
    wait_to(base + 1);
    chk(to_hist[base % 64] - mark == 128, "R4 lone AA ignored", to_hist[base % 64] - mark, 128);

    service(mark, base); idle(40); put(8'h55); put(8'h12); put(8'hAA);
    wait_to(base + 1);
    chk(to_hist[base % 64] - mark == 128, "R5 junk between keys", to_hist[base % 64] - mark, 128);

    service(mark, base); idle(40); put(8'h55); put(8'h55); put(8'hAA);
    mark2 = cyc; base = to_count;
    wait_to(base + 1);
    chk(to_hist[base % 64] - mark2 == 128, "R5 doubled first key", to_hist[base % 64] - mark2, 128);

    en = 1'b0;
    @(negedge clk);
    base = to_count;
    idle(300);
    chk(to_count == base, "R7 no timeout while disabled", to_count - base, 0);
    en = 1'b1;
    @(negedge clk);
    mark = cyc; base = to_count;
    wait_to(base + 1);
    chk(to_hist[base % 64] - mark == 127, "R7 full period after enable", to_hist[base % 64] - mark, 127);

    for (int i = 0; i < 20; i++) begin
      n = $urandom % 5;
      junk = $urandom % 3;
      rate_sel = 3'(n);
      for (int j = 0; j < junk; j++) begin
        b = 8'($urandom);
        while (b == 8'h55 || b == 8'hAA) b = 8'($urandom);
        put(b);
      end
      service(mark, base);
      wait_to(base + 1);
      chk(to_hist[base % 64] - mark == period_of(n), $sformatf("R1 R5 random code %0d", n),
          to_hist[base % 64] - mark, period_of(n));
    end

    chk(width_err == 0, "R2 pulse width one clock", width_err, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule